// File: doc/BRIEF.md
# Counter-Ramp ADC Controller

This block holds the digital half of a staircase analog-to-digital converter. A binary counter drives the code of an external DAC. A comparator reports, synchronously and on one bit, whether the analog input is still above the DAC output. While that bit is high the counter climbs one code per clock, so the DAC output rises as a staircase.

When the comparator falls, the count reached at that moment is the conversion result. It is copied into a holding register and announced with a one-cycle valid strobe. The counter goes back to zero on the same clock edge. The ramp then starts again by itself, so the converter produces one result after another with no start command. The time between results is one cycle longer than the code being converted.

If the input lies above the top of the DAC range, the counter stops at full scale. The block then raises an over-range flag and reports full scale as the result.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, the DAC code, the result, the valid strobe and the over-range flag all read zero (the result takes the RESULT_INIT parameter, zero by default).
- R2: On each clock edge where the comparator input is high and the DAC code is below all ones, the DAC code increases by exactly one.
- R3: On the edge where the comparator is sampled low after having been high on the previous edge, the result register takes the DAC code present before that edge, and the valid strobe is high for the following cycle.
- R4: On every edge where the comparator is sampled low, the DAC code returns to zero, and it stays at zero for as long as the comparator stays low.
- R5: For a steady input level L from 1 to all ones (the comparator high exactly while the DAC code is below L), every result after the first equals L, results arrive L+1 cycles apart, and the over-range flag stays low, including when L is full scale.
- R6: A comparator held low for several cycles gives only one valid pulse, and the result register does not change in any cycle in which the valid strobe is low.
- R7: When the DAC code is all ones and the comparator is still high, the DAC code holds at all ones, the over-range flag rises, and all ones is reported as a result with a single valid pulse.
- R8: The over-range flag clears on the first edge where the comparator is sampled low, and the falling edge is still reported as a normal result.
- R9: With an input level of zero (comparator never high), no valid pulse occurs, the DAC code stays zero and the previous result is kept.
- R10: Reset clears the stored comparator history, so a comparator that is high during reset and low at once after it produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_hi_i | input | 1 | Comparator: high while the analog input is above the DAC output |
| dac_code_o | output | WIDTH | Code driven to the external DAC |
| result_o | output | WIDTH | Last captured conversion result |
| result_valid_o | output | 1 | One-cycle strobe marking a new result |
| over_range_o | output | 1 | High while the ramp is pinned at full scale |

## Verification
The bench drives the comparator from a behavioural model of the analog side. This checks that each result equals the input level and that results arrive exactly L+1 cycles apart. A counter that reloaded a cycle late or captured after the reload would be off by one in either the value or the period. The top code is converted both with and without over-range. A design that confused the two would wrongly raise the flag at an input of exactly full scale, or would wrap to zero instead of holding when the input is above full scale. A comparator held low checks that a level-sensitive capture would repeat the strobe, and a zero input checks that no result is produced at all. A comparator high during reset and low just after it exposes an edge register that reset does not clear, because that design would report a false result.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;

  // Reason a result is written into the holding register this cycle
  typedef enum logic [1:0] {
    CAP_NONE = 2'd0,
    CAP_FALL = 2'd1,
    CAP_SAT  = 2'd2
  } cap_cause_e;

endpackage

// File: rtl/ramp_adc_edge.sv
module ramp_adc_edge (
  input  logic clk,
  input  logic rst,
  input  logic cmp_i,
  output logic fall_o
);

  logic cmp_q;

  always_ff @(posedge clk) begin
    if (rst) cmp_q <= 1'b0;
    else     cmp_q <= cmp_i;
  end

  assign fall_o = cmp_q & ~cmp_i;

endmodule

// File: rtl/ramp_adc_counter.sv
module ramp_adc_counter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] count_o,
  output logic             at_top_o
);

  localparam logic [WIDTH-1:0] TOP  = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};
  localparam logic [WIDTH-1:0] ZERO = {WIDTH{1'b0}};

  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= ZERO;
    else if (!cmp_i)       cnt_q <= ZERO;
    else if (cnt_q != TOP) cnt_q <= cnt_q + ONE;
  end

  assign count_o  = cnt_q;
  assign at_top_o = (cnt_q == TOP);

  // R2
  step_up_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_i && count_o != TOP) |=> (count_o == $past(count_o) + ONE));

  // R4
  reload_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !cmp_i |=> (count_o == ZERO));

endmodule

// File: rtl/ramp_adc_capture.sv
module ramp_adc_capture
  import ramp_adc_pkg::*;
#(
  parameter int               WIDTH       = 8,
  parameter logic [WIDTH-1:0] RESULT_INIT = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_i,
  input  cap_cause_e       cause_i,
  input  logic [WIDTH-1:0] count_i,
  output logic [WIDTH-1:0] result_o,
  output logic             valid_o,
  output logic             ovr_o
);

  logic [WIDTH-1:0] res_q;
  logic             vld_q;
  logic             ovr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= RESULT_INIT;
      vld_q <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      unique case (cause_i)
        CAP_FALL, CAP_SAT: begin
          res_q <= count_i;
          vld_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                    ovr_q <= 1'b0;
    else if (!cmp_i)            ovr_q <= 1'b0;
    else if (cause_i == CAP_SAT) ovr_q <= 1'b1;
  end

  assign result_o = res_q;
  assign valid_o  = vld_q;
  assign ovr_o    = ovr_q;

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> $stable(result_o));

  // R8
  ovr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !cmp_i |=> !ovr_o);

endmodule

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl
  import ramp_adc_pkg::*;
#(
  parameter int               WIDTH       = 8,
  parameter logic [WIDTH-1:0] RESULT_INIT = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_hi_i,
  output logic [WIDTH-1:0] dac_code_o,
  output logic [WIDTH-1:0] result_o,
  output logic             result_valid_o,
  output logic             over_range_o
);

  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  logic       fall;
  logic       at_top;
  cap_cause_e cause;

  ramp_adc_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .cmp_i  (cmp_hi_i),
    .fall_o (fall)
  );

  ramp_adc_counter #(.WIDTH(WIDTH)) u_counter (
    .clk      (clk),
    .rst      (rst),
    .cmp_i    (cmp_hi_i),
    .count_o  (dac_code_o),
    .at_top_o (at_top)
  );

  // A fall needs a low comparator and saturation a high one: never both
  always_comb begin
    if (fall)                                cause = CAP_FALL;
    else if (cmp_hi_i && at_top && !over_range_o) cause = CAP_SAT;
    else                                     cause = CAP_NONE;
  end

  ramp_adc_capture #(.WIDTH(WIDTH), .RESULT_INIT(RESULT_INIT)) u_capture (
    .clk      (clk),
    .rst      (rst),
    .cmp_i    (cmp_hi_i),
    .cause_i  (cause),
    .count_i  (dac_code_o),
    .result_o (result_o),
    .valid_o  (result_valid_o),
    .ovr_o    (over_range_o)
  );

  // R3
  capture_value_chk: assert property (@(posedge clk) disable iff (rst)
    result_valid_o |-> (result_o == $past(dac_code_o)));

  // R7
  sat_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_hi_i && dac_code_o == TOP) |=> (over_range_o && dac_code_o == TOP));

endmodule

// File: tb/ramp_adc_ctrl_tb.sv
`timescale 1ns/1ps
module ramp_adc_ctrl_tb;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cmp = 1'b0;
  logic [W-1:0] dac;
  logic [W-1:0] res;
  logic         vld;
  logic         ovr;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  ramp_adc_ctrl #(.WIDTH(W)) u_dut (
    .clk            (clk),
    .rst            (rst),
    .cmp_hi_i       (cmp),
    .dac_code_o     (dac),
    .result_o       (res),
    .result_valid_o (vld),
    .over_range_o   (ovr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // advance to the next falling edge and update the modelled comparator
  task automatic a_step(input int vin);
    @(negedge clk);
    cmp = (int'(dac) < vin);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    cmp = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    cmp = 1'b0;
    repeat (3) @(negedge clk);
    chk(dac == 0, "R1", "dac in reset", int'(dac), 0);
    chk(res == 0, "R1", "result in reset", int'(res), 0);
    chk(vld == 0, "R1", "valid in reset", int'(vld), 0);
    chk(ovr == 0, "R1", "ovr in reset", int'(ovr), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(dac == 0 && vld == 0, "R1", "first cycle after reset", int'(dac), 0);
  endtask

  task automatic t_direct();
    cmp = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      chk(dac == W'(k), "R2", "step count", int'(dac), k);
    end
    cmp = 1'b0;
    @(negedge clk);
    chk(vld == 1, "R3", "valid after fall", int'(vld), 1);
    chk(res == 4, "R3", "captured value", int'(res), 4);
    chk(dac == 0, "R4", "reload on low", int'(dac), 0);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      chk(vld == 0, "R6", "no repeat strobe", int'(vld), 0);
      chk(res == 4, "R6", "result held", int'(res), 4);
      chk(dac == 0, "R4", "held at zero", int'(dac), 0);
    end
    cmp = 1'b1;
    repeat (2) @(negedge clk);
    chk(dac == 2, "R2", "restart ramp", int'(dac), 2);
    chk(res == 4 && vld == 0, "R6", "result kept during ramp", int'(res), 4);
  endtask

  task automatic t_level(input int vin);
    int nv   = 0;
    int last = 0;
    for (int cyc = 0; cyc < 2000 && nv < 3; cyc++) begin
      a_step(vin);
      if (vld) begin
        if (nv > 0) begin
          chk(res == W'(vin), "R5", "level result", int'(res), vin);
          chk(cyc - last == vin + 1, "R5", "result period", cyc - last, vin + 1);
          chk(ovr == 0, "R5", "no over-range", int'(ovr), 0);
        end
        nv++;
        last = cyc;
      end
    end
    chk(nv == 3, "R5", "result count", nv, 3);
  endtask

  task automatic t_zero();
    logic [W-1:0] held;
    int nv = 0;
    repeat (3) a_step(0);
    held = res;
    for (int k = 0; k < 20; k++) begin
      a_step(0);
      if (vld) nv++;
      chk(dac == 0, "R9", "dac at zero", int'(dac), 0);
    end
    chk(nv == 0, "R9", "no strobe at zero input", nv, 0);
    chk(res == held, "R9", "result kept", int'(res), int'(held));
  endtask

  task automatic t_sat();
    int cyc = 0;
    do_reset();
    cmp = 1'b1;
    while (cyc < 400) begin
      a_step(300);
      cyc++;
      if (vld) break;
    end
    chk(cyc == 256, "R7", "saturation strobe cycle", cyc, 256);
    chk(res == 255, "R7", "full-scale result", int'(res), 255);
    chk(ovr == 1, "R7", "over-range set", int'(ovr), 1);
    for (int k = 0; k < 5; k++) begin
      a_step(300);
      chk(vld == 0, "R7", "single strobe", int'(vld), 0);
      chk(dac == 255 && ovr == 1, "R7", "hold at top", int'(dac), 255);
    end
    a_step(100);
    @(negedge clk);
    chk(vld == 1, "R8", "fall after saturation", int'(vld), 1);
    chk(res == 255, "R8", "fall result", int'(res), 255);
    chk(ovr == 0, "R8", "over-range cleared", int'(ovr), 0);
    chk(dac == 0, "R4", "reload after saturation", int'(dac), 0);
    cmp = (int'(dac) < 100);
    t_level(100);
  endtask

  task automatic t_reset_edge();
    int nv = 0;
    repeat (10) a_step(50);
    @(negedge clk);
    rst = 1'b1;
    cmp = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    cmp = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (vld) nv++;
    end
    chk(nv == 0, "R10", "no false result after reset", nv, 0);
    chk(res == 0, "R10", "result still cleared", int'(res), 0);
  endtask

  initial begin
    t_reset();
    t_direct();
    t_level(1);
    t_level(7);
    t_level(255);
    t_level(200);
    t_zero();
    t_sat();
    t_reset_edge();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule